// File: doc/BRIEF.md
# Dual Wiper Register Update Unit

This block keeps two wiper position registers for a pair of digitally adjusted resistors and applies already-decoded commands to them. A command arrives as a 4-bit code, a channel-select bit and a data field, qualified by a one-cycle valid strobe. The unit supports direct loads, linear single-code steps up or down, and logarithmic steps that double or halve the code. Each step type comes in a one-channel form and an all-channel form.

An active-low write-protect input blocks every command-driven change. A separate restore path has one load enable per channel. A store sequencer outside this block uses it to copy saved settings back into the registers, and it works whatever the protect level. The serial front end and the nonvolatile store are outside this block. The outputs are the two wiper codes, and a new code appears on the clock edge that samples the command.

Top module: `dual_wiper_update`

## Requirements
- R1: After reset both wipers hold midscale, code 512.
- R2: Command code 11 loads data_i into the channel named by addr_lsb_i (0 selects channel 0, 1 selects channel 1). The other channel is left unchanged, and the new value is on wiper_o after the clock edge that samples cmd_valid_i.
- R3: Code 14 adds one to the selected wiper and code 15 adds one to both. A wiper at 1023 stays at 1023.
- R4: Code 6 subtracts one from the selected wiper and code 7 subtracts one from both. A wiper at 0 stays at 0.
- R5: Code 12 doubles the selected wiper and code 13 doubles both. A value of 0 becomes 1, and any value of 512 or more becomes 1023.
- R6: Code 4 halves the selected wiper and code 5 halves both, dropping the least significant bit.
- R7: While wp_ni is low, no command changes either wiper.
- R8: When restore_ld_i[n] is high, wiper n takes its slice of restore_val_i on the next edge, whatever the level of wp_ni. In that same cycle the restore wins over any command for that channel.
- R9: Codes 0, 1, 2, 3, 8, 9 and 10, and any cycle with cmd_valid_i low, leave both wipers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 4 | Command code |
| addr_lsb_i | input | 1 | Channel select for one-channel commands |
| data_i | input | 10 | Load value for code 11 |
| wp_ni | input | 1 | Write protect, active low |
| restore_ld_i | input | 2 | Per-channel restore load enable |
| restore_val_i | input | 20 | Restore values, channel 0 in bits 9:0 |
| wiper_o | output | 20 | Wiper codes, channel 0 in bits 9:0 |

## Verification
The bench drives each end of the code range. It increments at 1023 and decrements at 0, where a design without saturation would wrap to the opposite end. It doubles 0 and values at or above 512: a plain shift would leave 0 stuck or drop the top bit. It also halves odd codes, where a rounding error would show. It issues commands while protected and collides restores with commands in the same cycle, which exposes a protect gate that also masks restores or a priority order that is backwards. Random mixes then check that channel select never touches the wrong wiper.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    OP_HOLD, OP_LOAD, OP_INC, OP_DEC, OP_DBL, OP_HALF
  } wiper_op_e;

  localparam logic [3:0] CMD_HALF_ONE = 4'd4;
  localparam logic [3:0] CMD_HALF_ALL = 4'd5;
  localparam logic [3:0] CMD_DEC_ONE  = 4'd6;
  localparam logic [3:0] CMD_DEC_ALL  = 4'd7;
  localparam logic [3:0] CMD_LOAD     = 4'd11;
  localparam logic [3:0] CMD_DBL_ONE  = 4'd12;
  localparam logic [3:0] CMD_DBL_ALL  = 4'd13;
  localparam logic [3:0] CMD_INC_ONE  = 4'd14;
  localparam logic [3:0] CMD_INC_ALL  = 4'd15;
endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import wiper_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_i,
  input  logic       addr_lsb_i,
  input  logic       wp_ni,
  output wiper_op_e  op_o
);
  logic sel;
  assign sel = (addr_lsb_i == CH_IDX[0]);

  always_comb begin
    op_o = OP_HOLD;
    if (cmd_valid_i && wp_ni) begin
      unique case (cmd_i)
        CMD_LOAD:     op_o = sel ? OP_LOAD : OP_HOLD;
        CMD_INC_ONE:  op_o = sel ? OP_INC  : OP_HOLD;
        CMD_INC_ALL:  op_o = OP_INC;
        CMD_DEC_ONE:  op_o = sel ? OP_DEC  : OP_HOLD;
        CMD_DEC_ALL:  op_o = OP_DEC;
        CMD_DBL_ONE:  op_o = sel ? OP_DBL  : OP_HOLD;
        CMD_DBL_ALL:  op_o = OP_DBL;
        CMD_HALF_ONE: op_o = sel ? OP_HALF : OP_HOLD;
        CMD_HALF_ALL: op_o = OP_HALF;
        default:      op_o = OP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/wiper_step_alu.sv
module wiper_step_alu
  import wiper_pkg::*;
#(
  parameter int WIPER_W = 10
) (
  input  wiper_op_e            op_i,
  input  logic [WIPER_W-1:0]   cur_i,
  input  logic [WIPER_W-1:0]   data_i,
  output logic [WIPER_W-1:0]   nxt_o
);
  localparam logic [WIPER_W-1:0] CODE_MAX  = {WIPER_W{1'b1}};
  localparam logic [WIPER_W-1:0] CODE_ZERO = '0;
  localparam logic [WIPER_W-1:0] CODE_ONE  = WIPER_W'(1);

  always_comb begin
    nxt_o = cur_i;
    unique case (op_i)
      OP_LOAD: nxt_o = data_i;
      OP_INC:  nxt_o = (cur_i == CODE_MAX)  ? CODE_MAX  : cur_i + CODE_ONE;
      OP_DEC:  nxt_o = (cur_i == CODE_ZERO) ? CODE_ZERO : cur_i - CODE_ONE;
      OP_DBL: begin
        // top bit set means at or above midscale: pin to full scale
        if (cur_i[WIPER_W-1])        nxt_o = CODE_MAX;
        else if (cur_i == CODE_ZERO) nxt_o = CODE_ONE;
        else                         nxt_o = {cur_i[WIPER_W-2:0], 1'b0};
      end
      OP_HALF: nxt_o = {1'b0, cur_i[WIPER_W-1:1]};
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/wiper_reg_slice.sv
module wiper_reg_slice #(
  parameter int WIPER_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restore_ld_i,
  input  logic [WIPER_W-1:0] restore_val_i,
  input  logic [WIPER_W-1:0] nxt_i,
  output logic [WIPER_W-1:0] q_o
);
  localparam logic [WIPER_W-1:0] CODE_MID = {1'b1, {(WIPER_W-1){1'b0}}};

  // restore outranks command and ignores write protect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           q_o <= CODE_MID;
    else if (restore_ld_i) q_o <= restore_val_i;
    else                   q_o <= nxt_i;
  end
endmodule

// File: rtl/dual_wiper_update.sv
module dual_wiper_update
  import wiper_pkg::*;
#(
  parameter int WIPER_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [3:0]             cmd_i,
  input  logic                   addr_lsb_i,
  input  logic [WIPER_W-1:0]     data_i,
  input  logic                   wp_ni,
  input  logic [1:0]             restore_ld_i,
  input  logic [2*WIPER_W-1:0]   restore_val_i,
  output logic [2*WIPER_W-1:0]   wiper_o
);
  localparam int NUM_CH = 2;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wiper_op_e          op;
    logic [WIPER_W-1:0] nxt;

    wiper_cmd_decode #(.CH_IDX(ch)) u_dec (
      .cmd_valid_i (cmd_valid_i),
      .cmd_i       (cmd_i),
      .addr_lsb_i  (addr_lsb_i),
      .wp_ni       (wp_ni),
      .op_o        (op)
    );

    wiper_step_alu #(.WIPER_W(WIPER_W)) u_alu (
      .op_i   (op),
      .cur_i  (wiper_o[ch*WIPER_W +: WIPER_W]),
      .data_i (data_i),
      .nxt_o  (nxt)
    );

    wiper_reg_slice #(.WIPER_W(WIPER_W)) u_reg (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .restore_ld_i  (restore_ld_i[ch]),
      .restore_val_i (restore_val_i[ch*WIPER_W +: WIPER_W]),
      .nxt_i         (nxt),
      .q_o           (wiper_o[ch*WIPER_W +: WIPER_W])
    );
  end
endmodule

// File: rtl/wiper_update_chk.sv
module wiper_update_chk #(
  parameter int WIPER_W = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [3:0]           cmd_i,
  input logic                 addr_lsb_i,
  input logic [WIPER_W-1:0]   data_i,
  input logic                 wp_ni,
  input logic [1:0]           restore_ld_i,
  input logic [2*WIPER_W-1:0] restore_val_i,
  input logic [2*WIPER_W-1:0] wiper_o
);
  localparam logic [WIPER_W-1:0] CODE_MAX = {WIPER_W{1'b1}};
  logic [WIPER_W-1:0] w0;
  logic do_cmd;
  assign w0 = wiper_o[WIPER_W-1:0];
  assign do_cmd = cmd_valid_i && wp_ni && !restore_ld_i[0];

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_cmd && cmd_i == 4'd11 && !addr_lsb_i) |=> (w0 == $past(data_i)));

  p_inc_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_cmd && cmd_i == 4'd15 && w0 == CODE_MAX) |=> (w0 == CODE_MAX));

  p_dec_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_cmd && cmd_i == 4'd7 && w0 == '0) |=> (w0 == '0));

  p_dbl_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_cmd && cmd_i == 4'd13 && w0 == '0) |=> (w0 == WIPER_W'(1)));

  p_wp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && restore_ld_i == 2'b00) |=> $stable(wiper_o));

  p_restore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_ld_i[0] |=> (w0 == $past(restore_val_i[WIPER_W-1:0])));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && restore_ld_i == 2'b00) |=> $stable(wiper_o));
endmodule

bind dual_wiper_update wiper_update_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .addr_lsb_i(addr_lsb_i), .data_i(data_i), .wp_ni(wp_ni),
  .restore_ld_i(restore_ld_i), .restore_val_i(restore_val_i), .wiper_o(wiper_o)
);

// File: tb/sim_dual_wiper_update.sv
`timescale 1ns/1ps
module sim_dual_wiper_update;
  localparam int W = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, a0 = 1'b0, wp_n = 1'b1;
  logic [3:0] cmd = '0;
  logic [W-1:0] dat = '0;
  logic [1:0] ld = '0;
  logic [2*W-1:0] rv = '0;
  logic [2*W-1:0] wo;
  logic [W-1:0] exp0, exp1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_wiper_update #(.WIPER_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld), .cmd_i(cmd),
    .addr_lsb_i(a0), .data_i(dat), .wp_ni(wp_n),
    .restore_ld_i(ld), .restore_val_i(rv), .wiper_o(wo));

  function automatic logic [W-1:0] model(input logic [3:0] c, input bit sel,
                                         input logic [W-1:0] v, input logic [W-1:0] d);
    case (c)
      4'd11: return sel ? d : v;
      4'd14, 4'd15: if (c == 4'd15 || sel) return (v == 10'd1023) ? v : v + 10'd1;
      4'd6, 4'd7: if (c == 4'd7 || sel) return (v == 10'd0) ? v : v - 10'd1;
      4'd12, 4'd13: if (c == 4'd13 || sel) begin
        if (v == 10'd0) return 10'd1;
        if (v >= 10'd512) return 10'd1023;
        return v << 1;
      end
      4'd4, 4'd5: if (c == 4'd5 || sel) return v >> 1;
      default: return v;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [3:0] c, input bit w, input logic [1:0] l);
    if (l != 2'b00) return "R8";
    if (!w) return "R7";
    case (c)
      4'd11: return "R2";
      4'd14, 4'd15: return "R3";
      4'd6, 4'd7: return "R4";
      4'd12, 4'd13: return "R5";
      4'd4, 4'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] c, input bit a, input logic [W-1:0] d,
                      input bit w, input logic [1:0] l, input logic [W-1:0] r0,
                      input logic [W-1:0] r1);
    string t;
    @(negedge clk);
    vld = v; cmd = c; a0 = a; dat = d; wp_n = w; ld = l; rv = {r1, r0};
    t = v ? tag_of(c, w, l) : (l != 0 ? "R8" : "R9");
    if (v && w) begin
      exp0 = model(c, a == 1'b0, exp0, d);
      exp1 = model(c, a == 1'b1, exp1, d);
    end
    if (l[0]) exp0 = r0;
    if (l[1]) exp1 = r1;
    @(posedge clk); #1;
    vld = 1'b0; ld = 2'b00;
    check({t, " ch0"}, wo[W-1:0], exp0);
    check({t, " ch1"}, wo[2*W-1:W], exp1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    exp0 = 10'd512; exp1 = 10'd512;
    #7 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ch0", wo[W-1:0], 10'd512);
    check("R1 ch1", wo[2*W-1:W], 10'd512);
    step(1, 4'd11, 0, 10'd0,    1, 0, 0, 0);   // R2 load ch0
    step(1, 4'd11, 1, 10'd1023, 1, 0, 0, 0);   // R2 load ch1
    step(1, 4'd7,  0, 0, 1, 0, 0, 0);          // R4 floor on ch0
    step(1, 4'd15, 0, 0, 1, 0, 0, 0);          // R3 ceiling on ch1
    step(1, 4'd14, 1, 0, 1, 0, 0, 0);          // R3 single, saturated
    step(1, 4'd6,  1, 0, 1, 0, 0, 0);          // R4 single
    step(1, 4'd11, 0, 10'd0, 1, 0, 0, 0);
    step(1, 4'd12, 0, 0, 1, 0, 0, 0);          // R5 zero -> 1
    step(1, 4'd12, 0, 0, 1, 0, 0, 0);          // R5 1 -> 2
    step(1, 4'd11, 1, 10'd600, 1, 0, 0, 0);
    step(1, 4'd13, 0, 0, 1, 0, 0, 0);          // R5 600 -> 1023, 2 -> 4
    step(1, 4'd11, 0, 10'd7, 1, 0, 0, 0);
    step(1, 4'd4,  0, 0, 1, 0, 0, 0);          // R6 odd halve
    step(1, 4'd5,  0, 0, 1, 0, 0, 0);          // R6 both
    step(1, 4'd11, 0, 10'd99, 0, 0, 0, 0);     // R7 protected load
    step(1, 4'd15, 0, 0, 0, 0, 0, 0);          // R7 protected inc
    step(1, 4'd11, 0, 10'd5, 0, 2'b11, 10'd300, 10'd301); // R8 under protect
    step(1, 4'd11, 0, 10'd5, 1, 2'b01, 10'd44, 0);        // R8 priority
    step(1, 4'd9,  0, 10'd3, 1, 0, 0, 0);      // R9
    step(1, 4'd1,  1, 10'd3, 1, 0, 0, 0);      // R9
    step(0, 4'd11, 1, 10'd3, 1, 0, 0, 0);      // R9 strobe low
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c; logic [W-1:0] d;
      c = 4'($urandom);
      d = ($urandom % 4 == 0) ? (($urandom % 2) ? 10'd1023 : 10'd0) : W'($urandom);
      step(($urandom % 8) != 0, c, 1'($urandom), d, ($urandom % 4) != 0,
           (($urandom % 8) == 0) ? 2'($urandom) : 2'b00, W'($urandom), W'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule